// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter

This block turns 8-bit characters into asynchronous serial frames on a single output line. A character enters through a valid/ready handshake and waits in a one-entry holding stage. When the serialiser is free, the character moves into it. The serialiser then sends a start bit, the data bits least significant first, an optional parity bit and the stop period. Bit timing comes from a 16x tick made by a built-in divisor counter that runs on the block clock.

The frame format comes from a 7-bit line-control input and can be changed at run time:

- `line_ctl[1:0]` selects the character length.
- `line_ctl[2]` selects the stop length.
- `line_ctl[3]` enables parity.
- `line_ctl[4]` selects even parity.
- `line_ctl[5]` selects stick parity.
- `line_ctl[6]` forces a break.

The format fields are captured together with the character when it enters the serialiser. The break control is applied live at the output.

Back-pressure rules for the input stream:
- A character is taken on a rising clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high exactly when the holding stage is empty.
- While `in_ready` is low, the source keeps `in_valid` and `in_data` steady; nothing is dropped.
- A character waiting in the holding stage starts its frame on the same edge that ends the previous stop period, so back-to-back frames have no idle gap.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is 1 and `in_ready`, `hold_empty` and `shift_empty` are all 1.
- R2: `line_ctl[1:0]` sets the data bits per character: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of `in_data` are not sent.
- R3: A frame starts with one 0 bit, then sends the data bits least significant first. Start, data and parity bits each last 16 ticks of `tick_16x`.
- R4: With `line_ctl[3]`=1 and `line_ctl[5]`=0, a parity bit follows the data. With `line_ctl[4]`=1 it makes the count of ones in data plus parity even; with `line_ctl[4]`=0 it makes that count odd. With `line_ctl[3]`=0 there is no parity bit.
- R5: With `line_ctl[3]`=1 and `line_ctl[5]`=1, the parity bit is the constant inverse of `line_ctl[4]`.
- R6: The stop period is held at 1 for:
  - 16 ticks when `line_ctl[2]`=0;
  - 32 ticks when `line_ctl[2]`=1;
  - 24 ticks when `line_ctl[2]`=1 and `line_ctl[1:0]`=0.
- R7: While `line_ctl[6]` is 1, `txd` is 0. Clearing `line_ctl[6]` restores the line to what the serialiser drives.
- R8: `tick_16x` pulses once every `divisor` clock cycles. With `divisor`=1 it is high on every cycle; with `divisor`=0 it never pulses.
- R9: Characters are accepted per the valid/ready rules above and transmitted in order, with no loss and no gap between back-to-back frames.
- R10: `shift_empty` is 1 only when no frame is in progress (the last stop tick has passed) and no character is waiting.
- R11: The format used for a frame is the `line_ctl[5:0]` value present when the character enters the serialiser. Later changes to `line_ctl[5:0]` do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the divisor reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Baud divisor: high byte in [15:8], low byte in [7:0] |
| line_ctl | input | 7 | Frame format and break control (fields as in R2 to R7) |
| in_valid | input | 1 | Source presents a character |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Holding stage can take a character |
| txd | output | 1 | Serial output line, idles high |
| tick_16x | output | 1 | 16x bit-rate tick |
| hold_empty | output | 1 | Holding stage is empty |
| shift_empty | output | 1 | Serialiser idle and nothing waiting |

## Verification
The bench covers every character length and every stop length, including the 1.5-stop case. A design that mixed up the half stop would end 5-bit frames 8 ticks early or late. It covers odd, even and both stick-parity senses, so an inverted parity sense shows as a wrong parity bit. It sends two characters back to back while a third is held off by back-pressure. A lost, duplicated or reordered character, or an idle gap between frames, changes the decoded frame sequence or the measured stop length. It also changes the format in the middle of a frame to catch a serialiser that follows the live format. It checks that break drives the line low at idle and releases it afterwards.

// File: rtl/uft_pkg.sv
package uft_pkg;

  localparam int CHAR_W = 8;
  localparam int LC_W   = 7;

  // line-control field positions (decoded by the serialiser and the top)
  localparam int LC_LEN   = 0;
  localparam int LC_STOP  = 2;
  localparam int LC_PEN   = 3;
  localparam int LC_EVEN  = 4;
  localparam int LC_STICK = 5;
  localparam int LC_BRK   = 6;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PARITY, PH_STOP
  } phase_t;

  typedef struct packed {
    logic [2:0] last_idx;   // index of last data bit
    logic       par_en;
    logic       par_bit;
    logic       long_stop;  // two stop bits (or 1.5 at 5 bits)
    logic       half_stop;  // long stop is 1.5 bits
  } frame_fmt_t;

  function automatic frame_fmt_t decode_fmt(input logic [5:0] lc,
                                            input logic [CHAR_W-1:0] d);
    frame_fmt_t f;
    logic [CHAR_W-1:0] masked;
    f.last_idx = 3'd4 + {1'b0, lc[LC_LEN +: 2]};
    for (int i = 0; i < CHAR_W; i++)
      masked[i] = (3'(i) <= f.last_idx) ? d[i] : 1'b0;
    f.par_en = lc[LC_PEN];
    if (lc[LC_STICK])
      f.par_bit = ~lc[LC_EVEN];
    else
      f.par_bit = lc[LC_EVEN] ? (^masked) : ~(^masked);
    f.long_stop = lc[LC_STOP];
    f.half_stop = (lc[LC_LEN +: 2] == 2'b00);
    return f;
  endfunction

endpackage

// File: rtl/uft_baud_div.sv
module uft_baud_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= divisor - 1'b1);
  assign tick = (divisor != '0) && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (divisor == '0)    cnt <= '0;
    else if (wrap)             cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uft_hold.sv
module uft_hold
  import uft_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [CHAR_W-1:0] data
);
  assign in_ready = ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/uft_shifter.sv
module uft_shifter
  import uft_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [5:0]        fmt_ctl,
  input  logic              hold_full,
  input  logic [CHAR_W-1:0] hold_data,
  output logic              take,
  output logic              line_bit,
  output logic              busy
);
  localparam int TCW = $clog2(2 * OVERSAMPLE);
  localparam logic [TCW-1:0] LAST_BIT  = TCW'(OVERSAMPLE - 1);
  localparam logic [TCW-1:0] LAST_1P5  = TCW'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
  localparam logic [TCW-1:0] LAST_TWO  = TCW'(2 * OVERSAMPLE - 1);

  phase_t            phase;
  frame_fmt_t        fmt;
  logic [TCW-1:0]    tcnt;
  logic [TCW-1:0]    last_cnt;
  logic [2:0]        idx;
  logic [CHAR_W-1:0] shreg;
  logic              bit_end;

  always_comb begin
    last_cnt = LAST_BIT;
    if (phase == PH_STOP && fmt.long_stop)
      last_cnt = fmt.half_stop ? LAST_1P5 : LAST_TWO;
  end

  assign bit_end = tick && (phase != PH_IDLE) && (tcnt == last_cnt);
  assign take    = hold_full && ((phase == PH_IDLE) || (phase == PH_STOP && bit_end));
  assign busy    = (phase != PH_IDLE);

  always_comb begin
    unique case (phase)
      PH_START:  line_bit = 1'b0;
      PH_DATA:   line_bit = shreg[0];
      PH_PARITY: line_bit = fmt.par_bit;
      default:   line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      fmt   <= '0;
      tcnt  <= '0;
      idx   <= '0;
      shreg <= '0;
    end else if (take) begin
      phase <= PH_START;
      fmt   <= decode_fmt(fmt_ctl, hold_data);
      tcnt  <= '0;
      idx   <= '0;
      shreg <= hold_data;
    end else if (tick && phase != PH_IDLE) begin
      if (bit_end) begin
        tcnt <= '0;
        unique case (phase)
          PH_START: phase <= PH_DATA;
          PH_DATA: begin
            shreg <= shreg >> 1;
            if (idx == fmt.last_idx)
              phase <= fmt.par_en ? PH_PARITY : PH_STOP;
            else
              idx <= idx + 1'b1;
          end
          PH_PARITY: phase <= PH_STOP;
          default:   phase <= PH_IDLE;
        endcase
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [LC_W-1:0]   line_ctl,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd,
  output logic              tick_16x,
  output logic              hold_empty,
  output logic              shift_empty
);
  logic              hold_full;
  logic [CHAR_W-1:0] hold_data;
  logic              take;
  logic              line_bit;
  logic              busy;

  uft_baud_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick_16x)
  );

  uft_hold u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .take(take), .full(hold_full), .data(hold_data)
  );

  uft_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .fmt_ctl(line_ctl[5:0]),
    .hold_full(hold_full), .hold_data(hold_data), .take(take),
    .line_bit(line_bit), .busy(busy)
  );

  assign txd         = line_ctl[LC_BRK] ? 1'b0 : line_bit;
  assign hold_empty  = ~hold_full;
  assign shift_empty = ~busy & ~hold_full;
endmodule

// File: rtl/uft_checks.sv
module uft_checks #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             brk,
  input logic [DIV_W-1:0] divisor,
  input logic             tick,
  input logic             txd,
  input logic             in_valid,
  input logic             in_ready,
  input logic             hold_empty,
  input logic             shift_empty
);
  assert_idle_line_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_empty && !brk) |-> txd);

  assert_break_forces_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  assert_accept_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!hold_empty && !shift_empty));

  assert_zero_div_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> !tick);

  assert_unit_div_every_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == DIV_W'(1) && $past(divisor) == DIV_W'(1)) |-> tick);

  assert_line_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(txd) && !brk && !$past(brk)) |-> ($past(tick) || !$past(hold_empty)));
endmodule

bind uart_frame_tx uft_checks #(.DIV_W(DIV_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .brk(line_ctl[6]), .divisor(divisor),
  .tick(tick_16x), .txd(txd), .in_valid(in_valid), .in_ready(in_ready),
  .hold_empty(hold_empty), .shift_empty(shift_empty)
);

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = '0;
  logic [6:0]  line_ctl = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, txd, tick_16x, hold_empty, shift_empty;

  always #2.5 clk = ~clk;

  uart_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .line_ctl(line_ctl),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd),
    .tick_16x(tick_16x), .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  typedef struct { logic [7:0] data; logic [6:0] lc; } item_t;
  item_t exp_q[$];
  int checks = 0, fails = 0, sent = 0, frames = 0;
  logic mon_en = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [6:0] lc);
    return 5 + int'(lc[1:0]);
  endfunction
  function automatic int stop_of(input logic [6:0] lc);
    if (!lc[2]) return 16;
    return (lc[1:0] == 2'b00) ? 24 : 32;
  endfunction
  function automatic logic [7:0] mask_of(input logic [7:0] d, input logic [6:0] lc);
    return d & 8'((1 << nbits_of(lc)) - 1);
  endfunction
  function automatic logic par_of(input logic [7:0] d, input logic [6:0] lc);
    logic ones;
    ones = ^mask_of(d, lc);
    if (lc[5]) return ~lc[4];
    return lc[4] ? ones : ~ones;
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  // driver: push expected item and present the character
  task automatic send(input logic [7:0] d);
    step();
    while (!in_ready) step();
    in_valid = 1'b1;
    in_data  = d;
    exp_q.push_back('{data: d, lc: line_ctl});
    sent++;
    step();
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    step();
    while (!shift_empty) step();
    repeat (3) step();
  endtask

  // monitor: decode frames on txd and compare with the scoreboard queue
  item_t cur;
  bit act = 1'b0;
  int k, nb, nd;
  logic [7:0] rxd;
  logic rxp, st_ok, sp_ok;

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (act && k >= nb * 16 && (shift_empty || !txd)) begin
        frames++;
        chk(st_ok && rxd == mask_of(cur.data, cur.lc), "R2 R3", "start+data",
            int'(rxd), int'(mask_of(cur.data, cur.lc)));
        if (cur.lc[3])
          chk(rxp == par_of(cur.data, cur.lc), cur.lc[5] ? "R5" : "R4",
              "parity bit", int'(rxp), int'(par_of(cur.data, cur.lc)));
        chk(k == nb * 16 + stop_of(cur.lc), "R6", "ticks to end of stop",
            k, nb * 16 + stop_of(cur.lc));
        chk(sp_ok, "R10", "stop high and shift_empty low", int'(sp_ok), 1);
        act = 1'b0;
      end
      if (!act && !txd && !line_ctl[6]) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected frame, queue size", 0, 1);
        end else begin
          cur = exp_q.pop_front();
          nd = nbits_of(cur.lc);
          nb = 1 + nd + (cur.lc[3] ? 1 : 0);
          k = 0; rxd = '0; rxp = 1'b0; st_ok = 1'b0; sp_ok = 1'b1;
          act = 1'b1;
        end
      end
      if (act && tick_16x) begin
        k++;
        if ((k - 1) % 16 == 7) begin
          int b;
          b = (k - 1) / 16;
          if (b == 0) st_ok = (txd == 1'b0);
          else if (b <= nd) rxd[b-1] = txd;
          else if (b == nd + 1 && cur.lc[3]) rxp = txd;
          else if (txd != 1'b1 || shift_empty) sp_ok = 1'b0;
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int n;
    repeat (4) step();
    chk(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
    rst_n = 1'b1;
    step();
    chk(txd && in_ready && hold_empty && shift_empty, "R1", "idle flags after reset",
        int'({txd, in_ready, hold_empty, shift_empty}), 15);

    // R8: divisor behaviour
    n = 0; for (int i = 0; i < 12; i++) begin n += tick_16x; step(); end
    chk(n == 0, "R8", "ticks with divisor 0", n, 0);
    divisor = 16'd1; step(); step();
    n = 0; for (int i = 0; i < 20; i++) begin n += tick_16x; step(); end
    chk(n == 20, "R8", "ticks with divisor 1", n, 20);
    divisor = 16'd3; step(); step();
    n = 0; for (int i = 0; i < 30; i++) begin n += tick_16x; step(); end
    chk(n == 10, "R8", "ticks with divisor 3", n, 10);
    divisor = 16'd0; step(); step();
    n = 0; for (int i = 0; i < 12; i++) begin n += tick_16x; step(); end
    chk(n == 0, "R8", "ticks after returning to divisor 0", n, 0);

    divisor = 16'd2;
    mon_en = 1'b1;
    step();

    // formats: R2 lengths, R4 parity, R5 stick, R6 stop lengths
    line_ctl = 7'h03; send(8'hA5); wait_idle();
    line_ctl = 7'h04; send(8'h1B); wait_idle();
    line_ctl = 7'h09; send(8'h2D); wait_idle();
    line_ctl = 7'h1E; send(8'h55); wait_idle();
    line_ctl = 7'h1F; send(8'hC3); wait_idle();
    line_ctl = 7'h3B; send(8'hFF); wait_idle();
    line_ctl = 7'h28; send(8'h00); wait_idle();
    line_ctl = 7'h06; send(8'hF3); wait_idle();

    // R9: back-pressure and back-to-back
    line_ctl = 7'h0B;
    send(8'h01);
    send(8'h80);
    chk(!in_ready && !hold_empty && !shift_empty, "R9", "ready/empty while full",
        int'({in_ready, hold_empty, shift_empty}), 0);
    send(8'h7E);
    wait_idle();

    // R11: format change after the character entered the serialiser
    line_ctl = 7'h03;
    send(8'h96);
    while (!hold_empty) step();
    line_ctl = 7'h1C;
    wait_idle();
    line_ctl = 7'h03;
    step();

    // R7: break at idle
    mon_en = 1'b0;
    line_ctl = 7'h43; step();
    chk(txd == 1'b0, "R7", "txd under break", int'(txd), 0);
    chk(shift_empty == 1'b1, "R7", "shift_empty under break", int'(shift_empty), 1);
    line_ctl = 7'h03; step();
    chk(txd == 1'b1, "R7", "txd after break release", int'(txd), 1);
    mon_en = 1'b1;
    step();

    chk(exp_q.size() == 0, "R9", "items left in scoreboard", exp_q.size(), 0);
    chk(frames == sent, "R9", "frames decoded", frames, sent);
    finish_run();
  end
endmodule